// File: doc/BRIEF.md
# Receive Signaling Serial Output Formatter

This block produces one serial signaling bit per recovered line clock for a single receive channel of a T1/E1 framer. A framer upstream supplies the time-slot number, the bit position inside the slot and the CAS multiframe frame number. It also supplies a flat vector holding a four-bit signaling nibble for each time slot. The formatter drops the right signaling bits into the right bit positions, so that a downstream device can pick up the signaling next to the payload serial stream.

T1 robbed-bit signaling comes out in 2-, 4- or 16-code form at the upper bit positions of every slot. For E1, the signaling can be spread across the slots in the same way. It can also be packed into time slot 16 in multiframe order, with two channels per frame and the alignment and spare bits in frame 0. At the first bit of each slot the needed nibbles are frozen, so a signaling store that changes in the middle of a slot never produces a mixed nibble.

Top module: `rx_sig_serializer`

## Requirements
- R1: While `if_en` is 0, `sig_out` is 0 at every bit position in every mode.
- R2: In per-slot placement with `code_sel` = 2 or 3 (16-code), bit positions 4, 5, 6 and 7 of slot s carry bits 3, 2, 1 and 0 of nibble s (A..D, where A is nibble bit 3). Nibble s sits at `sig_nib[4*s+3:4*s]`.
- R3: In per-slot placement with `code_sel` = 1 (4-code), positions 4 and 5 carry nibble bits 3 and 2, and positions 6 and 7 output 0.
- R4: In per-slot placement with `code_sel` = 0 (2-code), only position 4 carries nibble bit 3, and every other position outputs 0.
- R5: In per-slot placement, bit positions 0 to 3 of every slot output 0.
- R6: With `e1_mode` = 1 and `ts16_pack` = 0, placement follows R2 to R4, and slots 0 and 16 output 0 at all positions.
- R7: With `e1_mode` = 1 and `ts16_pack` = 1, only slot 16 carries signaling. In frame k (1 to 15), positions 0 to 3 carry nibble k bits 3 down to 0, and positions 4 to 7 carry nibble k+16 bits 3 down to 0.
- R8: In packed mode frame 0, slot 16 positions 0 to 3 output 0, and positions 4 to 7 carry `mf_spare` bits 3 down to 0 (x, y, x, x).
- R9: The nibbles used for a slot are taken in the cycle whose `bit_pos` is 0. A change to `sig_nib` or `mf_spare` at a later position of that slot does not change that slot's output.
- R10: `sig_out` is registered. It shows the bit for the counter values presented one clock edge earlier, and it is 0 during and directly after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Recovered line bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| if_en | input | 1 | Signaling output enable |
| e1_mode | input | 1 | 1 = E1 framing, 0 = T1 framing |
| ts16_pack | input | 1 | E1 only: 1 = pack signaling into slot 16 |
| code_sel | input | 2 | 0 = 2-code, 1 = 4-code, 2/3 = 16-code |
| slot | input | 5 | Current time slot number |
| bit_pos | input | 3 | Bit position within slot, 0 first |
| mf_frame | input | 4 | Frame number inside the CAS multiframe |
| sig_nib | input | 128 | Per-slot ABCD nibbles, nibble s at bits 4s+3..4s |
| mf_spare | input | 4 | Frame-0 x,y,x,x bits, bit 3 sent first |
| sig_out | output | 1 | Serial signaling output |

## Verification
The snapshot and the bit selection have no feedback of their own. A wrong internal value therefore shows on `sig_out` exactly one clock after the affected bit position is presented, and it shows again on every later slot that uses it. A snapshot loaded at the wrong moment shows up within the same slot, as soon as `sig_nib` is changed in mid-slot. A wrong code mask or slot gate shows up in the first frame swept in that mode. A wrong frame-to-channel mapping in packed mode takes up to one full multiframe of 16 frames to show.

// File: rtl/rxsig_pkg.sv
package rxsig_pkg;

  typedef enum logic [1:0] {
    CODE_2  = 2'd0,
    CODE_4  = 2'd1,
    CODE_16 = 2'd2,
    CODE_16B = 2'd3
  } code_e;

  localparam int NIB_W = 4;

  // Number of signaling bits carried per slot for a code width.
  function automatic int unsigned sig_bits(input code_e c);
    case (c)
      CODE_2:  return 1;
      CODE_4:  return 2;
      default: return 4;
    endcase
  endfunction

  // Per-slot placement: signaling starts at position 4, A first.
  function automatic logic slot_bit(input code_e c, input logic [3:0] nib,
                                    input logic [2:0] pos);
    int unsigned off;
    if (!pos[2]) return 1'b0;
    off = int'(pos[1:0]);
    if (off >= sig_bits(c)) return 1'b0;
    return nib[3 - off];
  endfunction

  // Packed slot 16: first nibble on positions 0..3, second on 4..7.
  function automatic logic pack_bit(input logic [3:0] first, input logic [3:0] second,
                                    input logic [2:0] pos);
    logic [7:0] octet;
    octet = {first, second};
    return octet[3'd7 - pos];
  endfunction

endpackage

// File: rtl/rxsig_fetch.sv
module rxsig_fetch #(
  parameter int NSLOT    = 32,
  parameter int SLOT_W   = 5,
  parameter int FRAME_W  = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 slot_start,
  input  logic                 packed_mode,
  input  logic [SLOT_W-1:0]    slot,
  input  logic [FRAME_W-1:0]   mf_frame,
  input  logic [NSLOT*4-1:0]   sig_nib,
  input  logic [3:0]           mf_spare,
  output logic [3:0]           live_a,
  output logic [3:0]           live_b,
  output logic [3:0]           snap_a,
  output logic [3:0]           snap_b
);
  localparam int HALF = NSLOT / 2;

  logic [SLOT_W-1:0] idx_a;
  logic [SLOT_W-1:0] idx_b;
  logic              frame_zero;

  always_comb begin
    frame_zero = (mf_frame == '0);
    idx_a = packed_mode ? SLOT_W'(mf_frame) : slot;
    idx_b = SLOT_W'(mf_frame) + SLOT_W'(HALF);
  end

  always_comb begin
    live_a = sig_nib[idx_a*4 +: 4];
    live_b = sig_nib[idx_b*4 +: 4];
    if (packed_mode && frame_zero) begin
      live_a = 4'b0000;
      live_b = mf_spare;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      snap_a <= '0;
      snap_b <= '0;
    end else if (slot_start) begin
      snap_a <= live_a;
      snap_b <= live_b;
    end
  end

  // R9: the frozen nibbles only move at the start of a slot
  assert_snap_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_start |=> ($stable(snap_a) && $stable(snap_b)));

endmodule

// File: rtl/rxsig_select.sv
module rxsig_select
  import rxsig_pkg::*;
#(
  parameter int SLOT_W  = 5,
  parameter int PACK_TS = 16
) (
  input  logic              if_en,
  input  logic              e1_mode,
  input  logic              packed_mode,
  input  code_e             code,
  input  logic [SLOT_W-1:0] slot,
  input  logic [2:0]        bit_pos,
  input  logic [3:0]        nib_a,
  input  logic [3:0]        nib_b,
  output logic              slot_live,
  output logic              next_bit
);
  logic is_pack_slot;
  logic is_e1_idle;

  always_comb begin
    is_pack_slot = (slot == SLOT_W'(PACK_TS));
    is_e1_idle   = e1_mode && ((slot == '0) || is_pack_slot);
    if (packed_mode) slot_live = is_pack_slot;
    else             slot_live = !is_e1_idle;
  end

  always_comb begin
    next_bit = 1'b0;
    if (if_en && slot_live) begin
      if (packed_mode) next_bit = pack_bit(nib_a, nib_b, bit_pos);
      else             next_bit = slot_bit(code, nib_a, bit_pos);
    end
  end

endmodule

// File: rtl/rx_sig_serializer.sv
module rx_sig_serializer
  import rxsig_pkg::*;
#(
  parameter int NSLOT   = 32,
  parameter int SLOT_W  = $clog2(NSLOT),
  parameter int FRAME_W = 4,
  parameter int PACK_TS = NSLOT / 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 if_en,
  input  logic                 e1_mode,
  input  logic                 ts16_pack,
  input  logic [1:0]           code_sel,
  input  logic [SLOT_W-1:0]    slot,
  input  logic [2:0]           bit_pos,
  input  logic [FRAME_W-1:0]   mf_frame,
  input  logic [NSLOT*4-1:0]   sig_nib,
  input  logic [3:0]           mf_spare,
  output logic                 sig_out
);
  logic       slot_start;
  logic       packed_mode;
  code_e      code;
  logic [3:0] live_a, live_b, snap_a, snap_b;
  logic [3:0] use_a, use_b;
  logic       slot_live;
  logic       next_bit;

  assign slot_start  = (bit_pos == 3'd0);
  assign packed_mode = e1_mode && ts16_pack;
  assign code        = code_e'(code_sel);
  // At the first bit the snapshot is being loaded, so the live value is used.
  assign use_a = slot_start ? live_a : snap_a;
  assign use_b = slot_start ? live_b : snap_b;

  rxsig_fetch #(.NSLOT(NSLOT), .SLOT_W(SLOT_W), .FRAME_W(FRAME_W)) u_fetch (
    .clk(clk), .rst_n(rst_n), .slot_start(slot_start), .packed_mode(packed_mode),
    .slot(slot), .mf_frame(mf_frame), .sig_nib(sig_nib), .mf_spare(mf_spare),
    .live_a(live_a), .live_b(live_b), .snap_a(snap_a), .snap_b(snap_b)
  );

  rxsig_select #(.SLOT_W(SLOT_W), .PACK_TS(PACK_TS)) u_select (
    .if_en(if_en), .e1_mode(e1_mode), .packed_mode(packed_mode), .code(code),
    .slot(slot), .bit_pos(bit_pos), .nib_a(use_a), .nib_b(use_b),
    .slot_live(slot_live), .next_bit(next_bit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) sig_out <= 1'b0;
    else        sig_out <= next_bit;
  end

  // R1: disabled interface keeps the pin low
  assert_quiet_when_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !if_en |=> !sig_out);

  // R5: low half of a slot never carries per-slot signaling
  assert_low_half_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!packed_mode && !bit_pos[2]) |=> !sig_out);

  // R4: 2-code only drives position 4
  assert_two_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!packed_mode && code_sel == 2'd0 && bit_pos != 3'd4) |=> !sig_out);

  // R3: 4-code leaves positions 6 and 7 low
  assert_four_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!packed_mode && code_sel == 2'd1 && bit_pos[2:1] == 2'b11) |=> !sig_out);

  // R6: E1 slots 0 and 16 are empty in per-slot placement
  assert_e1_idle_slots_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (e1_mode && !ts16_pack && (slot == '0 || slot == SLOT_W'(PACK_TS))) |=> !sig_out);

  // R7: packed mode is silent outside slot 16
  assert_pack_only_ts16_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (packed_mode && slot != SLOT_W'(PACK_TS)) |=> !sig_out);

  // R8: frame 0 opens with four zero bits
  assert_align_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (packed_mode && mf_frame == '0 && !bit_pos[2]) |=> !sig_out);

endmodule

// File: tb/rx_sig_serializer_tb.sv
module rx_sig_serializer_tb;
  localparam int NSLOT = 32;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             if_en = 1'b0;
  logic             e1_mode = 1'b0;
  logic             ts16_pack = 1'b0;
  logic [1:0]       code_sel = 2'd2;
  logic [4:0]       slot = '0;
  logic [2:0]       bit_pos = '0;
  logic [3:0]       mf_frame = '0;
  logic [NSLOT*4-1:0] sig_nib = '0;
  logic [3:0]       mf_spare = 4'b0000;
  logic             sig_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  rx_sig_serializer u_dut (
    .clk(clk), .rst_n(rst_n), .if_en(if_en), .e1_mode(e1_mode), .ts16_pack(ts16_pack),
    .code_sel(code_sel), .slot(slot), .bit_pos(bit_pos), .mf_frame(mf_frame),
    .sig_nib(sig_nib), .mf_spare(mf_spare), .sig_out(sig_out)
  );

  task automatic check(input string req, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s slot=%0d bit=%0d frame=%0d got=%0b exp=%0b",
               req, slot, bit_pos, mf_frame, got, exp);
    end
  endtask

  function automatic logic [3:0] nib_of(input int s);
    return sig_nib[s*4 +: 4];
  endfunction

  function automatic void fill(input int seed);
    for (int s = 0; s < NSLOT; s++) sig_nib[s*4 +: 4] = 4'((s * 7 + seed) ^ (s >> 1));
  endfunction

  // Expected octet for one slot, built from the requirements; bit p is octet[7-p].
  function automatic logic [7:0] exp_octet(input int s, input logic [3:0] na,
                                           input logic [3:0] nb);
    int n;
    logic [7:0] o;
    o = 8'h00;
    if (!if_en) return o;                                  // R1
    if (e1_mode && ts16_pack) begin                        // R7, R8
      if (s == 16) o = {na, nb};
      return o;
    end
    if (e1_mode && (s == 0 || s == 16)) return o;          // R6
    n = (code_sel == 2'd0) ? 1 : (code_sel == 2'd1) ? 2 : 4;
    for (int k = 0; k < n; k++) o[3 - k] = na[3 - k];      // R2..R4, R5
    return o;
  endfunction

  function automatic string req_tag();
    if (!if_en) return "R1";
    if (e1_mode && ts16_pack) return (mf_frame == 0) ? "R8" : "R7";
    if (e1_mode) return "R6";
    if (code_sel == 2'd0) return "R4";
    if (code_sel == 2'd1) return "R3";
    return "R2";
  endfunction

  // Sweep one frame; mid_slot >= 0 rewrites that slot's nibble at bit 2 (R9).
  task automatic run_frame(input int nslots, input int mid_slot);
    logic [3:0] sa, sb;
    logic [7:0] oct;
    string tag;
    for (int s = 0; s < nslots; s++) begin
      for (int b = 0; b < 8; b++) begin
        slot = 5'(s);
        bit_pos = 3'(b);
        if (b == 0) begin
          if (e1_mode && ts16_pack) begin
            sa = (mf_frame == 0) ? 4'b0000 : nib_of(int'(mf_frame));
            sb = (mf_frame == 0) ? mf_spare : nib_of(int'(mf_frame) + 16);
          end else begin
            sa = nib_of(s);
            sb = 4'b0000;
          end
          oct = exp_octet(s, sa, sb);
        end
        tag = req_tag();
        if (s == mid_slot && b == 2) begin
          sig_nib[s*4 +: 4] = ~sig_nib[s*4 +: 4];
          sig_nib[(int'(mf_frame) + 16)*4 +: 4] = ~sig_nib[(int'(mf_frame) + 16)*4 +: 4];
          mf_spare = ~mf_spare;
          tag = "R9";
        end
        @(posedge clk);
        @(negedge clk);
        check(tag, sig_out, oct[7 - b]);                  // R10: one edge later
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R10", sig_out, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10", sig_out, 1'b0);

    // R1: disabled, full nibbles everywhere
    sig_nib = '1;
    mf_spare = 4'b1111;
    if_en = 1'b0;
    run_frame(24, -1);
    e1_mode = 1'b1;
    ts16_pack = 1'b1;
    mf_frame = 4'd3;
    run_frame(32, -1);

    // T1 code widths: R2, R3, R4, R5
    if_en = 1'b1;
    e1_mode = 1'b0;
    ts16_pack = 1'b0;
    for (int c = 0; c < 4; c++) begin
      code_sel = 2'(c);
      fill(c * 5 + 1);
      run_frame(24, -1);
    end

    // R9: mid-slot store change in T1 16-code, then the next frame sees it
    code_sel = 2'd2;
    fill(9);
    run_frame(24, 5);
    run_frame(24, -1);

    // E1 per-slot placement: R6
    e1_mode = 1'b1;
    for (int c = 0; c < 3; c++) begin
      code_sel = 2'(c);
      fill(c + 11);
      run_frame(32, -1);
    end

    // E1 packed slot 16 over a whole multiframe: R7, R8
    ts16_pack = 1'b1;
    fill(4);
    mf_spare = 4'b1011;
    for (int f = 0; f < 16; f++) begin
      mf_frame = 4'(f);
      run_frame(32, -1);
    end
    // R9 in packed mode, frames 0 and 6
    mf_frame = 4'd0;
    run_frame(32, 16);
    mf_frame = 4'd6;
    run_frame(32, 16);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule